// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Bus-Idle Detection

This block recovers asynchronous character frames from one serial input that rests at the high level. An external rate generator supplies a single-clock enable pulse at sixteen times the bit rate. The receiver uses those pulses to find the falling edge of a start bit and confirm it half a bit later. It then samples every following bit at its centre and rebuilds the character into a parallel word.

Run-time inputs select the frame shape:
- 7 or 8 data bits.
- An optional parity bit, even or odd.
- One or two stop bits.
- Least- or most-significant bit first.
- A multiprocessor variant in which the bit after the data is an address/data marker, not parity.

All of these settings must stay constant while a frame is in flight.

The word becomes available when the centre of the first stop bit is sampled. The full flag rises at that moment even when two stop bits are configured. The second stop bit is still checked, and it still counts as line activity. A separate bus-idle flag rises only once the last stop bit has fully elapsed and no new start edge has been seen. Software-side logic acknowledges a word with a one-cycle clear pulse.

Top module: `serial_rx`

## Requirements
- R1: After reset, data_o, addr_o, full_o, perr_o, ferr_o, ovr_o and idle_o are all 0.
- R2: A low level that has returned high by the start-bit centre, sampled 8 ticks after the edge is detected, is discarded and delivers no word.
- R3: With msb_first_i=0, the first data bit received lands in data_o[0]. In 7-bit mode (len8_i=0), data_o[7] reads 0.
- R4: With msb_first_i=1, the first data bit received lands in data_o[7] for 8-bit frames, or in data_o[6] for 7-bit frames.
- R5: With par_en_i=1 and mp_mode_i=0, one bit follows the data. perr_o is set when the XOR of the data bits and that bit differs from par_odd_i (0 selects even parity, 1 selects odd parity).
- R6: With mp_mode_i=1, the bit after the data is presented on addr_o, and perr_o stays 0. Outside that mode, addr_o reads 0.
- R7: ferr_o is set when the first stop bit samples low. With two_stop_i=1, it is also set when the second stop bit samples low.
- R8: full_o rises at the centre of the first stop bit and is already high during the second stop bit. A clear_i pulse drops full_o and ovr_o on the next clock.
- R9: When a frame reaches its first stop bit while full_o is high, ovr_o rises and data_o, addr_o, perr_o and ferr_o keep the earlier word's values.
- R10: idle_o rises 8 ticks after the centre of the last stop bit, provided the line stayed high. It remains 0 throughout a second stop bit.
- R11: A detected start edge clears idle_o on the next clock, so frames sent back to back keep idle_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| rx_i | input | 1 | Serial line, idles high |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present (normal mode) |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| two_stop_i | input | 1 | Two stop bits expected |
| msb_first_i | input | 1 | Most-significant data bit first |
| mp_mode_i | input | 1 | Multiprocessor mode, address/data bit after the data |
| clear_i | input | 1 | Acknowledge pulse, clears full and overrun |
| data_o | output | 8 | Received word |
| addr_o | output | 1 | Received address/data marker |
| full_o | output | 1 | Word available |
| perr_o | output | 1 | Parity error of the stored word |
| ferr_o | output | 1 | Framing error of the stored word |
| ovr_o | output | 1 | Overrun: a frame was lost |
| idle_o | output | 1 | Bus idle after the last stop bit |

## Verification
In the receiver's view, a bit spans 16 ticks after a two-flop synchronizer. Word, error and full results are therefore due on the clock of tick 8 of the first stop bit. The second-stop framing result is due at tick 8 of that bit. The bus-idle rise is due at tick 0 of the bit period after the last stop bit, and the idle clear comes one clock after the start edge is detected.

The bench drives each bit for exactly 16 ticks and samples on falling clock edges. For each bit it samples at tick 4, when the value before the update is still present, and at tick 12, when the new value must already hold. Every result is compared against a behavioural frame model, and a one-tick jitter in edge detection cannot move a result across either sample point.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP1, RX_STOP2, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              len8_i,
  input  logic              par_en_i,
  input  logic              two_stop_i,
  input  logic              msb_first_i,
  input  logic              mp_mode_i,
  output logic              start_o,
  output logic              frame_o,
  output logic              stop2_o,
  output logic              idle_set_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] word_o,
  output logic              extra_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx, pos;
  logic [DATA_W-1:0] word_q, word_d;
  logic              extra_q, extra_d;
  logic              has_extra, bit_due;

  assign last_idx  = len8_i ? IDX_W'(DATA_W-1) : IDX_W'(DATA_W-2);
  assign pos       = msb_first_i ? last_idx - idx_q : idx_q;
  assign has_extra = par_en_i | mp_mode_i;
  assign bit_due   = (cnt_q == CNT_FULL);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    word_d     = word_q;
    extra_d    = extra_q;
    start_o    = 1'b0;
    frame_o    = 1'b0;
    stop2_o    = 1'b0;
    idle_set_o = 1'b0;
    if (tick_i) begin
      case (state_q)
        RX_IDLE: if (!rx_i) begin
          state_d = RX_START; cnt_d = '0; start_o = 1'b1;
        end
        RX_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_d = '0;
            if (!rx_i) begin
              state_d = RX_DATA; idx_d = '0; word_d = '0; extra_d = 1'b0;
            end else begin
              state_d = RX_IDLE;   // glitch, not a start bit
            end
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (bit_due) begin
            cnt_d       = '0;
            word_d[pos] = rx_i;
            if (idx_q == last_idx) state_d = has_extra ? RX_EXTRA : RX_STOP1;
            else                   idx_d   = idx_q + 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_EXTRA: begin
          if (bit_due) begin
            cnt_d = '0; extra_d = rx_i; state_d = RX_STOP1;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_STOP1: begin
          if (bit_due) begin
            cnt_d = '0; frame_o = 1'b1;
            state_d = two_stop_i ? RX_STOP2 : RX_HOLD;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_STOP2: begin
          if (bit_due) begin
            cnt_d = '0; stop2_o = 1'b1; state_d = RX_HOLD;
          end else cnt_d = cnt_q + 1'b1;
        end
        RX_HOLD: begin
          // wait out the second half of the last stop bit
          if (!rx_i) begin
            state_d = RX_START; cnt_d = '0; start_o = 1'b1;
          end else if (cnt_q == CNT_HALF) begin
            state_d = RX_IDLE; idle_set_o = 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      extra_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      word_q  <= word_d;
      extra_q <= extra_d;
    end
  end

  assign stop_ok_o = rx_i;
  assign word_o    = word_q;
  assign extra_o   = extra_q;

  // R2
  evt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, frame_o, stop2_o, idle_set_o}));
  // R8
  frame_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> tick_i);
  // R7
  stop2_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop2_o |-> two_stop_i);
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              mp_mode_i,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              frame_i,
  input  logic              stop2_i,
  input  logic              idle_set_i,
  input  logic              stop_ok_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              extra_i,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              idle_o
);
  logic kept_q, store;

  assign store = frame_i & ~(full_o & ~clear_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      addr_o <= 1'b0;
      full_o <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
      idle_o <= 1'b0;
      kept_q <= 1'b0;
    end else begin
      full_o <= (full_o & ~clear_i) | frame_i;
      ovr_o  <= (ovr_o & ~clear_i) | (frame_i & ~store);
      if (frame_i) kept_q <= store;
      if (store) begin
        data_o <= word_i;
        addr_o <= mp_mode_i & extra_i;
        perr_o <= par_en_i & ~mp_mode_i & (^word_i ^ extra_i ^ par_odd_i);
        ferr_o <= ~stop_ok_i;
      end else if (stop2_i && kept_q && !stop_ok_i) begin
        ferr_o <= 1'b1;
      end
      if (start_i)         idle_o <= 1'b0;
      else if (idle_set_i) idle_o <= 1'b1;
    end
  end

  // R8
  full_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(frame_i));
  // R9
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && full_o && !clear_i |=> $stable(data_o) && ovr_o);
  // R11
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !idle_o);
  // R10
  idle_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(idle_set_i));
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              len8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic              msb_first_i,
  input  logic              mp_mode_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              idle_o
);
  logic              rx_s, start, frame, stop2, idle_set, stop_ok, extra;
  logic [DATA_W-1:0] word;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  serial_rx_fsm #(.OSR(OSR), .DATA_W(DATA_W)) i_fsm (
    .clk_i, .rst_ni, .tick_i, .rx_i(rx_s),
    .len8_i, .par_en_i, .two_stop_i, .msb_first_i, .mp_mode_i,
    .start_o(start), .frame_o(frame), .stop2_o(stop2), .idle_set_o(idle_set),
    .stop_ok_o(stop_ok), .word_o(word), .extra_o(extra)
  );

  serial_rx_flags #(.DATA_W(DATA_W)) i_flags (
    .clk_i, .rst_ni, .par_en_i, .par_odd_i, .mp_mode_i, .clear_i,
    .start_i(start), .frame_i(frame), .stop2_i(stop2), .idle_set_i(idle_set),
    .stop_ok_i(stop_ok), .word_i(word), .extra_i(extra),
    .data_o, .addr_o, .full_o, .perr_o, .ferr_o, .ovr_o, .idle_o
  );
endmodule

// File: tb/test_serial_rx.sv
`timescale 1ns/1ps
module test_serial_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, clear = 1'b0;
  logic len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic msb = 1'b0, mp = 1'b0;
  logic [7:0] data_o;
  logic addr_o, full_o, perr_o, ferr_o, ovr_o, idle_o;
  logic [1:0] tcnt;
  logic tick;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [7:0] m_data = '0;
  logic m_addr = 0, m_full = 0, m_perr = 0, m_ferr = 0, m_ovr = 0, m_kept = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0; else tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd3);

  serial_rx i_serial_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
    .len8_i(len8), .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .msb_first_i(msb), .mp_mode_i(mp), .clear_i(clear),
    .data_o, .addr_o, .full_o, .perr_o, .ferr_o, .ovr_o, .idle_o
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R3/R4 data"}, data_o, m_data);
    chk("R6 addr", {7'd0, addr_o}, {7'd0, m_addr});
    chk("R5 perr", {7'd0, perr_o}, {7'd0, m_perr});
    chk("R7 ferr", {7'd0, ferr_o}, {7'd0, m_ferr});
    chk("R8 full", {7'd0, full_o}, {7'd0, m_full});
    chk("R9 ovr", {7'd0, ovr_o}, {7'd0, m_ovr});
  endtask

  task automatic frame(input logic [7:0] d, input logic xb, input logic s1,
                       input logic s2, input string tag);
    int nb;
    logic [7:0] w;
    nb = len8 ? 8 : 7;
    w  = len8 ? d : {1'b0, d[6:0]};
    rx = 1'b0; ticks(4);
    chk("R11 idle low in start bit", {7'd0, idle_o}, 8'd0);
    ticks(12);
    for (int i = 0; i < nb; i++) begin
      rx = d[msb ? nb-1-i : i]; ticks(16);
    end
    if (par_en || mp) begin rx = xb; ticks(16); end
    rx = s1; ticks(4);
    chk("R8 full before stop1 centre", {7'd0, full_o}, {7'd0, m_full});
    ticks(8);
    if (m_full) begin
      m_ovr = 1; m_kept = 0;
    end else begin
      m_data = w;
      m_addr = mp & xb;
      m_perr = (par_en && !mp) ? (^w ^ xb ^ par_odd) : 1'b0;
      m_ferr = ~s1;
      m_full = 1; m_kept = 1;
    end
    chk_all(tag);
    ticks(4);
    if (two_stop) begin
      rx = s2; ticks(12);
      if (m_kept && !s2) m_ferr = 1;
      chk("R10 idle low in stop2", {7'd0, idle_o}, 8'd0);
      chk("R8 full during stop2", {7'd0, full_o}, {7'd0, m_full});
      chk("R7 ferr after stop2", {7'd0, ferr_o}, {7'd0, m_ferr});
      ticks(4);
    end
  endtask

  task automatic gap_chk(input logic exp);
    rx = 1'b1; ticks(4);
    chk("R10 idle after last stop", {7'd0, idle_o}, {7'd0, exp});
    ticks(12);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    m_full = 0; m_ovr = 0;
    chk("R8 clear full", {7'd0, full_o}, 8'd0);
    chk("R8 clear ovr", {7'd0, ovr_o}, 8'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ticks(2);
    chk("R1 reset data", data_o, 8'd0);
    chk("R1 reset flags", {2'd0, addr_o, full_o, perr_o, ferr_o, ovr_o, idle_o}, 8'd0);

    // 8N1 LSB first
    frame(8'hA5, 1'b0, 1'b1, 1'b1, "R3 8N1");
    gap_chk(1'b1);
    do_clear();

    // 7 bits, even parity
    len8 = 0; par_en = 1; par_odd = 0;
    frame(8'h53, 1'b0, 1'b1, 1'b1, "R5 even ok"); gap_chk(1'b1); do_clear();
    frame(8'h53, 1'b1, 1'b1, 1'b1, "R5 even bad"); gap_chk(1'b1); do_clear();
    frame(8'hD3, 1'b0, 1'b1, 1'b1, "R3 7-bit zero fill"); gap_chk(1'b1); do_clear();

    // 8 bits, odd parity, two stop, MSB first
    len8 = 1; par_odd = 1; two_stop = 1; msb = 1;
    frame(8'h3C, 1'b1, 1'b1, 1'b1, "R4 8O2"); gap_chk(1'b1); do_clear();
    frame(8'h81, 1'b0, 1'b1, 1'b0, "R7 stop2 low"); gap_chk(1'b0); do_clear();

    // 7 bits MSB first, no parity, one stop
    len8 = 0; par_en = 0; two_stop = 0;
    frame(8'h41, 1'b0, 1'b1, 1'b1, "R4 7-bit msb"); gap_chk(1'b1); do_clear();

    // multiprocessor mode
    len8 = 1; msb = 0; mp = 1; par_en = 1;
    frame(8'h5A, 1'b1, 1'b1, 1'b1, "R6 address"); gap_chk(1'b1); do_clear();
    frame(8'h5B, 1'b0, 1'b1, 1'b1, "R6 data"); gap_chk(1'b1);

    // overrun: no clear in between
    mp = 0; par_en = 0;
    frame(8'hC3, 1'b0, 1'b1, 1'b1, "R9 overrun keeps word"); gap_chk(1'b1);
    do_clear();

    // glitch shorter than half a bit
    rx = 1'b0; ticks(4); rx = 1'b1; ticks(40);
    chk("R2 glitch no word", {7'd0, full_o}, 8'd0);
    chk("R2 glitch data kept", data_o, m_data);

    // back-to-back frames, two stop bits
    two_stop = 1;
    frame(8'h11, 1'b0, 1'b1, 1'b1, "R11 b2b first"); do_clear();
    frame(8'h22, 1'b0, 1'b1, 1'b1, "R11 b2b second");
    gap_chk(1'b1); do_clear();

    // first stop bit low
    two_stop = 0;
    frame(8'h7E, 1'b0, 1'b0, 1'b1, "R7 stop1 low"); gap_chk(1'b0); do_clear();
    frame(8'h66, 1'b0, 1'b1, 1'b1, "R7 recovery"); gap_chk(1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule